// File: doc/BRIEF.md
# Feedback-Divider Slide Sequencer

This block moves a running PLL's feedback divider N to a new value without losing lock. It does not reprogram the PLL from scratch. It asks the PLL to enter its slowdown state, lets it settle, writes the coefficient word with the new N, lets it settle again, and then enables the PLL's dynamic ramp. It then waits for the ramp to report completion. The wait is bounded. If no completion arrives within the limit, the sequence still leaves through the normal exit path and reports an error. Waiting time is measured in microseconds from an external one-microsecond tick, so the block runs at any clock rate.

A request carries the target N and enters on a valid/ready handshake. The block samples the current M, N and PL coefficients when it accepts a request. Ready is low for the whole sequence, so the requester must hold or drop its request and cannot queue a second one. A request whose N already matches the current N completes at once and drives no control.

A separate configuration path decodes the reference clock rate, given in kHz, into the two 8-bit ramp step constants, one per configuration field. An unknown rate is refused with an error flag, and the constants keep their previous values.

Top module: `ndiv_slide_seq`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A request presented while busy has no effect: it starts no second write and changes no write data.
- R2: When the accepted `req_n` equals `cur_n`, `done` is high in the cycle after acceptance with `err` low. `slowdown`, `ramp_en` and `coef_wr` stay low throughout.
- R3: Otherwise `slowdown` rises in the cycle after acceptance. `coef_wr` pulses for one cycle, in the cycle after the SETTLE_US-th tick counted while `slowdown` is high. The write carries the requested N together with the M and PL captured at acceptance.
- R4: `ramp_en` rises after SETTLE_US further ticks counted after the write cycle. `slowdown` stays high for as long as `ramp_en` is high.
- R5: `ramp_done_async` passes through a two-flop synchronizer. When it rises, `ramp_en` stays high for exactly 3 sampled cycles, counting the cycle in which it is first seen high, and the sequence then ends with `err` low.
- R6: If TIMEOUT_US ticks are counted while `ramp_en` is high and no ramp-done is seen, the sequence ends with `err` high.
- R7: On success and on timeout alike, `slowdown` and `ramp_en` fall in the same cycle. `done` is high for exactly that one cycle, and `err` is high only together with `done`.
- R8: A `cfg_load` pulse decodes `ref_khz`. The values 12000, 12800 and 13000 give `step_a`=0x2b and `step_b`=0x0b. 19200 gives 0x12 and 0x08. 38400 gives 0x04 and 0x05. The new values are visible in the next cycle, and `cfg_err` is cleared.
- R9: A `cfg_load` with any other `ref_khz` sets `cfg_err` and leaves `step_a` and `step_b` unchanged.
- R10: After reset, the following are all low or zero: `slowdown`, `ramp_en`, `coef_wr`, `done`, `err`, `cfg_err`, `step_a` and `step_b`. `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request for a slide to `req_n` |
| req_ready | output | 1 | Sequencer idle; request accepted when valid is also high |
| req_n | input | N_W | Target feedback divider |
| cur_m | input | M_W | Current reference divider |
| cur_n | input | N_W | Current feedback divider |
| cur_pl | input | PL_W | Current post-divider code |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ramp_done_async | input | 1 | Ramp completion status from the PLL, asynchronous |
| slowdown | output | 1 | Slowdown mode request |
| ramp_en | output | 1 | Dynamic ramp enable |
| coef_wr | output | 1 | Coefficient write strobe |
| coef_m | output | M_W | Coefficient write data, M |
| coef_n | output | N_W | Coefficient write data, N |
| coef_pl | output | PL_W | Coefficient write data, PL |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Ramp timeout, valid with `done` |
| cfg_load | input | 1 | Decode `ref_khz` into the step constants |
| ref_khz | input | 16 | Reference clock rate in kHz |
| step_a | output | 8 | Ramp step constant A |
| step_b | output | 8 | Ramp step constant B |
| cfg_err | output | 1 | Last configuration load had an unsupported rate |

## Verification
The bench builds the sequencer with 3-bit M and N, a 2-bit PL, SETTLE_US of 2 and TIMEOUT_US of 12, and raises the tick every fourth clock. With these values, every pair of current and requested N can be swept in a few thousand cycles, covering both the equal-N shortcut and full slides. The ramp timeout also becomes reachable in about fifty cycles. The ramp model answers after a varying delay, which exercises the synchronizer latency and the settle windows against tick phases that differ from one sequence to the next. All five supported reference rates are loaded, mixed with unsupported ones, to confirm that the constants are retained.

// File: rtl/ndiv_slide_pkg.sv
package ndiv_slide_pkg;

  localparam int unsigned REF_W  = 16;
  localparam int unsigned STEP_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE_PRE,
    S_LOAD,
    S_SETTLE_POST,
    S_RAMP,
    S_FINISH
  } seq_state_t;

  typedef struct packed {
    logic              known;
    logic [STEP_W-1:0] a;
    logic [STEP_W-1:0] b;
  } step_cfg_t;

endpackage

// File: rtl/ndiv_sync2.sv
module ndiv_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ndiv_us_timer.sv
module ndiv_us_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/ndiv_step_table.sv
module ndiv_step_table
  import ndiv_slide_pkg::*;
(
  input  logic [REF_W-1:0] ref_khz,
  output step_cfg_t        cfg
);
  always_comb begin
    cfg = '{known: 1'b0, a: '0, b: '0};
    case (ref_khz)
      16'd12000, 16'd12800, 16'd13000: cfg = '{known: 1'b1, a: 8'h2b, b: 8'h0b};
      16'd19200:                       cfg = '{known: 1'b1, a: 8'h12, b: 8'h08};
      16'd38400:                       cfg = '{known: 1'b1, a: 8'h04, b: 8'h05};
      default:                         cfg = '{known: 1'b0, a: '0, b: '0};
    endcase
  end
endmodule

// File: rtl/ndiv_slide_seq.sv
module ndiv_slide_seq
  import ndiv_slide_pkg::*;
#(
  parameter int unsigned M_W         = 8,
  parameter int unsigned N_W         = 8,
  parameter int unsigned PL_W        = 6,
  parameter int unsigned SETTLE_US   = 1,
  parameter int unsigned TIMEOUT_US  = 500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [N_W-1:0]    req_n,
  input  logic [M_W-1:0]    cur_m,
  input  logic [N_W-1:0]    cur_n,
  input  logic [PL_W-1:0]   cur_pl,
  input  logic              us_tick,
  input  logic              ramp_done_async,
  output logic              slowdown,
  output logic              ramp_en,
  output logic              coef_wr,
  output logic [M_W-1:0]    coef_m,
  output logic [N_W-1:0]    coef_n,
  output logic [PL_W-1:0]   coef_pl,
  output logic              done,
  output logic              err,
  input  logic              cfg_load,
  input  logic [REF_W-1:0]  ref_khz,
  output logic [STEP_W-1:0] step_a,
  output logic [STEP_W-1:0] step_b,
  output logic              cfg_err
);
  localparam int unsigned LONGEST = (TIMEOUT_US > SETTLE_US) ? TIMEOUT_US : SETTLE_US;
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_US - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_US - 1);

  seq_state_t       state_q, state_d;
  logic             fail_q, fail_d;
  logic             accept;
  logic             timer_clr;
  logic [CNT_W-1:0] us_count;
  logic             ramp_done_s;
  logic             settle_hit;
  logic             timeout_hit;
  logic [M_W-1:0]   hold_m;
  logic [N_W-1:0]   hold_n;
  logic [PL_W-1:0]  hold_pl;
  step_cfg_t        decoded;

  ndiv_sync2 #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ramp_done_async),
    .q     (ramp_done_s)
  );

  ndiv_us_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .tick  (us_tick),
    .count (us_count)
  );

  ndiv_step_table u_steps (
    .ref_khz (ref_khz),
    .cfg     (decoded)
  );

  assign req_ready   = (state_q == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign settle_hit  = us_tick && (us_count == SETTLE_LAST);
  assign timeout_hit = us_tick && (us_count == TIMEOUT_LAST);

  always_comb begin
    state_d = state_q;
    fail_d  = fail_q;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          fail_d  = 1'b0;
          state_d = (req_n == cur_n) ? S_FINISH : S_SETTLE_PRE;
        end
      end
      S_SETTLE_PRE:  if (settle_hit) state_d = S_LOAD;
      S_LOAD:        state_d = S_SETTLE_POST;
      S_SETTLE_POST: if (settle_hit) state_d = S_RAMP;
      S_RAMP: begin
        if (ramp_done_s) begin
          state_d = S_FINISH;
          fail_d  = 1'b0;
        end else if (timeout_hit) begin
          state_d = S_FINISH;
          fail_d  = 1'b1;
        end
      end
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // Every state change restarts the microsecond count for the next window.
  assign timer_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_m  <= '0;
      hold_n  <= '0;
      hold_pl <= '0;
    end else if (accept) begin
      hold_m  <= cur_m;
      hold_n  <= req_n;
      hold_pl <= cur_pl;
    end
  end

  assign slowdown = (state_q == S_SETTLE_PRE) || (state_q == S_LOAD) ||
                    (state_q == S_SETTLE_POST) || (state_q == S_RAMP);
  assign ramp_en  = (state_q == S_RAMP);
  assign coef_wr  = (state_q == S_LOAD);
  assign coef_m   = hold_m;
  assign coef_n   = hold_n;
  assign coef_pl  = hold_pl;
  assign done     = (state_q == S_FINISH);
  assign err      = (state_q == S_FINISH) && fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_a  <= '0;
      step_b  <= '0;
      cfg_err <= 1'b0;
    end else if (cfg_load) begin
      if (decoded.known) begin
        step_a  <= decoded.a;
        step_b  <= decoded.b;
        cfg_err <= 1'b0;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ndiv_slide_chk.sv
module ndiv_slide_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       slowdown,
  input logic       ramp_en,
  input logic       coef_wr,
  input logic       done,
  input logic       err,
  input logic       cfg_err,
  input logic [7:0] step_a,
  input logic [7:0] step_b
);
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    slowdown |-> !req_ready);

  a_r3_write_in_slowdown: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr |-> slowdown);

  a_r3_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr |=> !coef_wr);

  a_r4_ramp_in_slowdown: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> slowdown);

  a_r7_exit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slowdown) |-> done);

  a_r7_ramp_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_en) |-> !slowdown);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r9_reject_keeps_steps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> ($stable(step_a) && $stable(step_b)));
endmodule

bind ndiv_slide_seq ndiv_slide_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .slowdown  (slowdown),
  .ramp_en   (ramp_en),
  .coef_wr   (coef_wr),
  .done      (done),
  .err       (err),
  .cfg_err   (cfg_err),
  .step_a    (step_a),
  .step_b    (step_b)
);

// File: tb/ndiv_slide_seq_tb_top.sv
`timescale 1ns/1ps
module ndiv_slide_seq_tb_top;
  localparam int M_W = 3, N_W = 3, PL_W = 2;
  localparam int SETTLE = 2, TIMEOUT = 12, TP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [N_W-1:0] req_n = '0, cur_n = '0, coef_n;
  logic [M_W-1:0] cur_m = '0, coef_m;
  logic [PL_W-1:0] cur_pl = '0, coef_pl;
  logic us_tick = 1'b0, ramp_raw = 1'b0;
  logic slowdown, ramp_en, coef_wr, done, err;
  logic cfg_load = 1'b0, cfg_err;
  logic [15:0] ref_khz = '0;
  logic [7:0] step_a, step_b;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ndiv_slide_seq #(.M_W(M_W), .N_W(N_W), .PL_W(PL_W), .SETTLE_US(SETTLE),
                   .TIMEOUT_US(TIMEOUT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_n(req_n), .cur_m(cur_m), .cur_n(cur_n), .cur_pl(cur_pl),
    .us_tick(us_tick), .ramp_done_async(ramp_raw), .slowdown(slowdown),
    .ramp_en(ramp_en), .coef_wr(coef_wr), .coef_m(coef_m), .coef_n(coef_n),
    .coef_pl(coef_pl), .done(done), .err(err), .cfg_load(cfg_load),
    .ref_khz(ref_khz), .step_a(step_a), .step_b(step_b), .cfg_err(cfg_err));

  // microsecond tick every TP clocks
  int tick_div = 0;
  always @(posedge clk) begin
    tick_div <= (tick_div == TP - 1) ? 0 : tick_div + 1;
    us_tick  <= (tick_div == TP - 1);
  end

  // ramp model: answers after rdelay cycles if ramp_resp is set
  bit ramp_resp = 1;
  int rdelay = 0, rcnt = 0;
  always @(posedge clk) begin
    if (!ramp_en) begin
      rcnt <= 0; ramp_raw <= 1'b0;
    end else if (ramp_resp && rcnt >= rdelay) ramp_raw <= 1'b1;
    else rcnt <= rcnt + 1;
  end

  // monitor
  int phase = 0, tk = 0, tk_w1 = 0, tk_w2 = 0, tk_r = 0, raw_hi = 0, raw_hi_done = 0;
  int slow_rises = 0, wr_cnt = 0, done_cnt = 0, dbl_done = 0;
  logic [N_W-1:0] wr_n; logic [M_W-1:0] wr_m; logic [PL_W-1:0] wr_pl;
  bit done_err, slow_at_done, ramp_at_done, pslow_at_done, pramp_at_done;
  bit pslow = 0, pramp = 0, pdone = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (slowdown && !pslow) begin phase = 1; tk = 0; slow_rises++; end
      if (done) begin
        done_cnt++; done_err = err; tk_r = tk; raw_hi_done = raw_hi;
        slow_at_done = slowdown; ramp_at_done = ramp_en;
        pslow_at_done = pslow; pramp_at_done = pramp; phase = 0;
        if (pdone) dbl_done++;
      end else if (coef_wr) begin
        wr_cnt++; wr_n = coef_n; wr_m = coef_m; wr_pl = coef_pl;
        tk_w1 = tk; tk = 0; phase = 2;
      end else if (ramp_en && !pramp) begin
        tk_w2 = tk; tk = us_tick ? 1 : 0; phase = 3; raw_hi = 0;
      end else if (us_tick && phase != 0) tk++;
      if (ramp_en && ramp_raw) raw_hi++;
      pslow = slowdown; pramp = ramp_en; pdone = done;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [N_W-1:0] n);
    int d0 = done_cnt;
    int guard = 0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_n = n;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (done_cnt == d0 && guard < 1000) begin @(posedge clk); guard++; end
    chk(done_cnt == d0 + 1, "R7 sequence completes once", done_cnt - d0, 1);
    #1;
  endtask

  task automatic cfg(input logic [15:0] r);
    @(posedge clk); #1;
    cfg_load = 1'b1; ref_khz = r;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int s0, w0, d0, ea, eb;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready after reset", req_ready, 1);
    chk({slowdown, ramp_en, coef_wr, done, err} === 5'b0, "R10 controls low", 1, 0);
    chk(step_a === 8'h00 && step_b === 8'h00 && cfg_err === 1'b0, "R10 config clear", step_a, 0);

    // R8 / R9: configuration sweep with a bench model of the retained values
    ea = 0; eb = 0;
    for (int i = 0; i < 9; i++) begin
      logic [15:0] r; bit known;
      case (i)
        0: r = 16'd12000; 1: r = 16'd11999; 2: r = 16'd19200;
        3: r = 16'd0;     4: r = 16'd38400; 5: r = 16'd12800;
        6: r = 16'd38401; 7: r = 16'd13000; default: r = 16'hffff;
      endcase
      known = 1;
      if (r == 12000 || r == 12800 || r == 13000) begin ea = 'h2b; eb = 'h0b; end
      else if (r == 19200) begin ea = 'h12; eb = 'h08; end
      else if (r == 38400) begin ea = 'h04; eb = 'h05; end
      else known = 0;
      cfg(r);
      chk(cfg_err === !known, known ? "R8 cfg_err cleared" : "R9 cfg_err set", cfg_err, !known);
      chk(step_a == ea[7:0], known ? "R8 step_a" : "R9 step_a kept", step_a, ea);
      chk(step_b == eb[7:0], known ? "R8 step_b" : "R9 step_b kept", step_b, eb);
    end

    // Sweep every (current N, requested N) pair
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 8; n++) begin
        cur_n = N_W'(c); cur_m = M_W'(7 - c); cur_pl = PL_W'(n);
        rdelay = (c + n) % 4; ramp_resp = 1;
        s0 = slow_rises; w0 = wr_cnt;
        send(N_W'(n));
        chk(done_err == 1'b0, "R5 no error on ramp done", done_err, 0);
        chk(dbl_done == 0, "R7 done single cycle", dbl_done, 0);
        if (c == n) begin
          chk(slow_rises == s0, "R2 no slowdown on equal N", slow_rises - s0, 0);
          chk(wr_cnt == w0, "R2 no write on equal N", wr_cnt - w0, 0);
        end else begin
          chk(wr_cnt == w0 + 1, "R3 one write", wr_cnt - w0, 1);
          chk(wr_n == N_W'(n) && wr_m == M_W'(7 - c) && wr_pl == PL_W'(n),
              "R3 write data", wr_n, n);
          chk(tk_w1 == SETTLE, "R3 settle before write", tk_w1, SETTLE);
          chk(tk_w2 == SETTLE, "R4 settle before ramp", tk_w2, SETTLE);
          chk(raw_hi_done == 3, "R5 sync latency", raw_hi_done, 3);
          chk(!slow_at_done && !ramp_at_done && pslow_at_done && pramp_at_done,
              "R7 joint exit", {slow_at_done, ramp_at_done}, 0);
        end
      end
    end

    // R6: timeout
    ramp_resp = 0; cur_n = 3'd1; cur_m = 3'd2; cur_pl = 2'd1;
    send(3'd5);
    chk(done_err == 1'b1, "R6 timeout error", done_err, 1);
    chk(tk_r == TIMEOUT, "R6 timeout window", tk_r, TIMEOUT);
    chk(!slow_at_done && !ramp_at_done && pslow_at_done && pramp_at_done,
        "R7 joint exit on timeout", {slow_at_done, ramp_at_done}, 0);
    @(negedge clk);
    chk(err === 1'b0, "R7 err only with done", err, 0);
    ramp_resp = 1;

    // R1: requests while busy are ignored
    cur_n = 3'd2; rdelay = 2; s0 = slow_rises; w0 = wr_cnt; d0 = done_cnt;
    @(posedge clk); #1; req_valid = 1'b1; req_n = 3'd6;
    @(posedge clk); #1; req_n = 3'd4;
    repeat (6) @(posedge clk);
    #1 req_valid = 1'b0;
    while (done_cnt == d0) @(posedge clk);
    repeat (40) @(posedge clk);
    chk(slow_rises == s0 + 1, "R1 single sequence", slow_rises - s0, 1);
    chk(wr_cnt == w0 + 1, "R1 single write", wr_cnt - w0, 1);
    chk(wr_n == 3'd6, "R1 busy request ignored", wr_n, 6);
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready when idle", req_ready, 1);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule